// File: doc/BRIEF.md
# Strapped-Address I2C Register Slave

This block is the serial control port of a four-channel amplifier. It is a target-only I2C interface that decodes a 7-bit device address, takes a register pointer, and then moves one or more data bytes into or out of a small register map. After each data byte, in either direction, the pointer moves on by one. The low two bits of the device address come from a 2-bit strap input. Up to four parts can therefore share one bus: the write/read byte pairs are D8/D9, DA/DB, DC/DD and DE/DF for strap values 0 to 3.

The map mixes access types. Status bytes are fed from the `status_i` bus and are read-only. Control bytes are read/write, hold reset defaults and drive the `ctrl_o` bus. The remaining addresses are holes. One control bit triggers a full return of the control bytes to their defaults and then clears itself. SCL and SDA are sampled in the system clock domain. The system clock must run at least 20 times the bus bit rate. SDA is driven open-drain through `sda_oe_o`.

Top module: `amp_ctrl_i2c_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address {5'b11011, strap_i}, which is bit 7 to bit 1 of the address byte. A transfer to any other address gets no acknowledge, and the block waits for the next start.
- R2: Bytes are received MSB first. The block pulls SDA low during the ninth clock of the address byte, the pointer byte and every written data byte. A single data byte lands in the register that the pointer names.
- R3: In a write that carries several data bytes, each byte goes to the current pointer, and the pointer then increments by one (modulo 256).
- R4: A read is a pointer write, then a repeated start, then the address with R/W=1. The block shifts bytes out MSB first, starting at the pointer, and increments the pointer after each byte. It continues while the master acknowledges and releases SDA after a not-acknowledge.
- R5: Control defaults after reset: 0x08=0xAA, 0x09=0xF0, 0x0A=0x0D, 0x0B=0x50, 0x0C=0x1F, 0x0D=0x00, 0x10=0x01. In 0x08 each channel n has a gain code in bits 2n+1:2n (00=12 dB, 01=20 dB, 10=26 dB, 11=32 dB), so the default is 26 dB on all four channels.
- R6: Reads of 0x00..0x07 return status_i[8n+7:8n] for address n. Reads of 0x13 return status_i[71:64]. Writes to these addresses are acknowledged and dropped.
- R7: Addresses 0x0E, 0x0F, 0x11, 0x12 and 0x14..0xFF read as 0x00. Writes to them are acknowledged and dropped.
- R8: In 0x0A, bits 1:0 hold the switching-frequency code and bits 3:2 hold the warning-pin select. A write whose bits 1:0 are 11 keeps the old frequency code and still updates bits 7:2.
- R9: Writing a 1 to bit 7 of 0x0C returns every control register to its R5 default one clock after the write. Bit 7 always reads as 0.
- R10: A stop condition inside a byte abandons the transfer, and the partial byte is not written. A start condition always opens a new address phase.
- R11: ctrl_o[8k+7:8k] carries control register k, taken in the order 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the bus bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Address strap, becomes address bits 1:0 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| status_i | input | 72 | Nine read-only status bytes |
| ctrl_o | output | 56 | Seven control register bytes |

## Verification
A behavioural bus master runs single-byte and burst writes and reads with repeated start. A burst that crosses from 0x0D over the holes to 0x10 tells apart correct pointer increment, hole decoding and correct control-slot mapping. Writes aimed at status addresses and holes show whether data leaks into control state. The invalid frequency code, the self-clearing reset bit, a wrong strap address and a stop in the middle of a byte each exercise one guarded path, and the mirrored control map is compared on every quiet clock.

// File: rtl/amp_ctrl_pkg.sv
package amp_ctrl_pkg;
  localparam int BYTE_W      = 8;
  localparam int NUM_CTRL    = 7;
  localparam int NUM_STAT    = 9;
  localparam int CTRL_CONTIG = 6;  // 0x08..0x0D, then one at 0x10
  localparam int STAT_CONTIG = 8;  // 0x00..0x07, then one at 0x13
  localparam logic [7:0] CTRL_BASE  = 8'h08;
  localparam logic [7:0] CTRL_EXTRA = 8'h10;
  localparam logic [7:0] STAT_EXTRA = 8'h13;
  localparam logic [7:0] SRST_ADDR  = 8'h0C;
  localparam logic [7:0] FREQ_ADDR  = 8'h0A;
  localparam logic [4:0] DEV_BASE   = 5'b11011;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} eng_state_e;
  typedef enum logic [1:0] {K_DEV, K_SUB, K_DATA} byte_kind_e;

  function automatic logic [7:0] ctrl_addr(int k);
    return (k < CTRL_CONTIG) ? CTRL_BASE + 8'(k) : CTRL_EXTRA;
  endfunction

  function automatic logic [7:0] stat_addr(int k);
    return (k < STAT_CONTIG) ? 8'(k) : STAT_EXTRA;
  endfunction

  function automatic logic [7:0] ctrl_default(int k);
    case (k)
      0: return 8'hAA;
      1: return 8'hF0;
      2: return 8'h0D;
      3: return 8'h50;
      4: return 8'h1F;
      5: return 8'h00;
      default: return 8'h01;
    endcase
  endfunction

  function automatic logic [NUM_CTRL*8-1:0] ctrl_default_vec();
    logic [NUM_CTRL*8-1:0] v;
    for (int k = 0; k < NUM_CTRL; k++) v[k*8 +: 8] = ctrl_default(k);
    return v;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import amp_ctrl_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   strap_i,
  input  logic         sda_i,
  input  logic         scl_rise_i,
  input  logic         scl_fall_i,
  input  logic         start_i,
  input  logic         stop_i,
  output logic         sda_oe_o,
  output logic         wr_en_o,
  output logic [W-1:0] wr_addr_o,
  output logic [W-1:0] wr_data_o,
  output logic [W-1:0] rd_addr_o,
  input  logic [W-1:0] rd_data_i
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  eng_state_e st_q;
  byte_kind_e kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0] sh_q, sub_q;
  logic rw_q, mack_q;

  assign rd_addr_o = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      kind_q    <= K_DEV;
      cnt_q     <= '0;
      sh_q      <= '0;
      sub_q     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st_q     <= S_RX;
        kind_q   <= K_DEV;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          S_RX: begin
            if (scl_rise_i && cnt_q < FULL) begin
              sh_q  <= {sh_q[W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              unique case (kind_q)
                K_DEV: begin
                  if (sh_q[W-1:1] == {DEV_BASE, strap_i}) begin
                    rw_q     <= sh_q[0];
                    sda_oe_o <= 1'b1;
                    st_q     <= S_ACK;
                  end else begin
                    st_q <= S_IDLE;
                  end
                end
                K_SUB: begin
                  sub_q    <= sh_q;
                  sda_oe_o <= 1'b1;
                  st_q     <= S_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= sub_q;
                  wr_data_o <= sh_q;
                  sub_q     <= sub_q + 1'b1;
                  sda_oe_o  <= 1'b1;
                  st_q      <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (kind_q == K_DEV && rw_q) begin
                sh_q     <= rd_data_i;
                sub_q    <= sub_q + 1'b1;
                sda_oe_o <= ~rd_data_i[W-1];
                st_q     <= S_TX;
              end else begin
                sda_oe_o <= 1'b0;
                st_q     <= S_RX;
                kind_q   <= (kind_q == K_DEV) ? K_SUB : K_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                sda_oe_o <= 1'b0;
                st_q     <= S_TXACK;
              end else begin
                sh_q     <= {sh_q[W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[W-2];
                cnt_q    <= cnt_q + 1'b1;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                cnt_q    <= '0;
                sh_q     <= rd_data_i;
                sub_q    <= sub_q + 1'b1;
                sda_oe_o <= ~rd_data_i[W-1];
                st_q     <= S_TX;
              end else begin
                st_q <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/amp_reg_bank.sv
module amp_reg_bank
  import amp_ctrl_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic [7:0]             rd_addr_i,
  output logic [7:0]             rd_data_o,
  input  logic [NUM_STAT*8-1:0]  status_i,
  output logic [NUM_CTRL*8-1:0]  ctrl_o,
  output logic                   soft_rst_o
);
  logic [7:0] ctrl_q [NUM_CTRL];
  logic srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= wr_en_i && wr_addr_i == SRST_ADDR && wr_data_i[7];
  end
  assign soft_rst_o = srst_q;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    localparam logic [7:0] ADDR = ctrl_addr(k);
    localparam logic [7:0] DEF  = ctrl_default(k);
    logic [7:0] nxt;
    if (ADDR == FREQ_ADDR) begin : g_freq
      assign nxt = {wr_data_i[7:2], (wr_data_i[1:0] == 2'b11) ? ctrl_q[k][1:0] : wr_data_i[1:0]};
    end else if (ADDR == SRST_ADDR) begin : g_srst
      assign nxt = {1'b0, wr_data_i[6:0]};
    end else begin : g_plain
      assign nxt = wr_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ctrl_q[k] <= DEF;
      else if (srst_q)                        ctrl_q[k] <= DEF;
      else if (wr_en_i && wr_addr_i == ADDR)  ctrl_q[k] <= nxt;
    end
    assign ctrl_o[k*8 +: 8] = ctrl_q[k];
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_STAT; k++)
      if (rd_addr_i == stat_addr(k)) rd_data_o = status_i[k*8 +: 8];
    for (int k = 0; k < NUM_CTRL; k++)
      if (rd_addr_i == ctrl_addr(k)) rd_data_o = ctrl_q[k];
  end
endmodule

// File: rtl/amp_ctrl_i2c_slave.sv
module amp_ctrl_i2c_slave
  import amp_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            strap_i,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [NUM_STAT*8-1:0] status_i,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic wr_en, soft_rst;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_byte_engine #(.W(BYTE_W)) i_eng (
    .clk_i, .rst_ni, .strap_i, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .sda_oe_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  amp_reg_bank i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .status_i, .ctrl_o,
    .soft_rst_o(soft_rst)
  );
endmodule

// File: rtl/amp_ctrl_i2c_checker.sv
module amp_ctrl_i2c_checker
  import amp_ctrl_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic                  soft_rst,
  input logic [NUM_CTRL*8-1:0] ctrl_o,
  input logic [7:0]            rd_addr,
  input logic [7:0]            rd_data
);
  logic hole;
  assign hole = (rd_addr == 8'h0E) || (rd_addr == 8'h0F) || (rd_addr == 8'h11) ||
                (rd_addr == 8'h12) || (rd_addr >= 8'h14);

  p_ack_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  p_soft_reset_defaults_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> ctrl_o == ctrl_default_vec());
  p_srst_bit_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[4*8 + 7] == 1'b0);
  p_freq_code_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[2*8 +: 2] != 2'b11);
  p_hole_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hole |-> rd_data == 8'h00);
endmodule

bind amp_ctrl_i2c_slave amp_ctrl_i2c_checker i_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .soft_rst, .ctrl_o, .rd_addr, .rd_data
);

// File: tb/test_amp_ctrl_i2c_slave.sv
`timescale 1ns/1ps
module test_amp_ctrl_i2c_slave;
  import amp_ctrl_pkg::*;

  localparam int Q  = 10;       // clocks per quarter bit
  localparam int WD = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_oe, sda_bus;
  logic [NUM_STAT*8-1:0] status;
  logic [NUM_CTRL*8-1:0] ctrl;

  int checks = 0, errors = 0, cyc = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [7:0] model [NUM_CTRL];
  logic [7:0] wbuf [8];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  amp_ctrl_i2c_slave i_amp_ctrl_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .status_i(status), .ctrl_o(ctrl)
  );

  function automatic logic [7:0] stat_val(int n);
    return 8'(8'h31 + 8'(n) * 8'h13);
  endfunction

  function automatic int slot_of(logic [7:0] a);
    if (a >= 8'h08 && a <= 8'h0D) return int'(a) - 8;
    if (a == 8'h10) return 6;
    return -1;
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] a);
    if (a <= 8'h07) return stat_val(int'(a));
    if (a == 8'h13) return stat_val(8);
    if (slot_of(a) >= 0) return model[slot_of(a)];
    return 8'h00;
  endfunction

  task automatic model_reset();
    model[0] = 8'hAA; model[1] = 8'hF0; model[2] = 8'h0D; model[3] = 8'h50;
    model[4] = 8'h1F; model[5] = 8'h00; model[6] = 8'h01;
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    int s = slot_of(a);
    if (s < 0) return;
    if (a == 8'h0A && d[1:0] == 2'b11) model[s] = {d[7:2], model[s][1:0]};
    else if (a == 8'h0C) begin
      if (d[7]) model_reset();
      else model[s] = d;
    end else model[s] = d;
  endtask

  function automatic logic [NUM_CTRL*8-1:0] model_vec();
    logic [NUM_CTRL*8-1:0] v;
    for (int k = 0; k < NUM_CTRL; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // every quiet clock: control outputs against the behavioural map (R11, R5)
  always @(negedge clk) begin
    if (rst_n && quiet) begin
      checks++;
      if (ctrl !== model_vec()) begin
        errors++;
        $display("FAIL R11 ctrl actual=%0h expected=%0h", ctrl, model_vec());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD);
      report();
    end
  end

  task automatic wq(int n); repeat (n) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask
  task automatic send_bit(logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic send_byte(logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = ~a;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~ack);
  endtask

  function automatic logic [7:0] dev(logic [1:0] s, logic rw);
    return {5'b11011, s, rw};
  endfunction

  task automatic wr_seq(logic [7:0] sub, int n, string req);
    logic ack;
    quiet = 1'b0;
    bus_start();
    send_byte(dev(strap, 1'b0), ack); check({req, " dev ack"}, ack, 1);
    send_byte(sub, ack);              check({req, " sub ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);        check({req, " data ack"}, ack, 1);
      model_write(sub + 8'(i), wbuf[i]);
    end
    bus_stop();
    wq(4);
    quiet = 1'b1;
  endtask

  task automatic rd_seq(logic [7:0] sub, int n, string req);
    logic ack;
    logic [7:0] d;
    quiet = 1'b0;
    bus_start();
    send_byte(dev(strap, 1'b0), ack); check({req, " dev ack"}, ack, 1);
    send_byte(sub, ack);              check({req, " sub ack"}, ack, 1);
    bus_start();
    send_byte(dev(strap, 1'b1), ack); check({req, " rd ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      check({req, " data"}, d, model_read(sub + 8'(i)));
    end
    check({req, " sda released"}, sda_oe, 0);
    bus_stop();
    wq(4);
    quiet = 1'b1;
  endtask

  initial begin
    logic ack;
    for (int n = 0; n < NUM_STAT; n++) status[n*8 +: 8] = stat_val(n);
    model_reset();
    wq(5);
    rst_n = 1'b1;
    wq(3);
    // R5: reset values, bus released
    check("R5 reset ctrl", ctrl, model_vec());
    check("R5 reset sda", sda_oe, 0);
    quiet = 1'b1;

    // R1: wrong strap address is not acknowledged
    quiet = 1'b0;
    bus_start(); send_byte(dev(2'd1, 1'b0), ack); check("R1 foreign addr nack", ack, 0);
    bus_stop(); wq(4); quiet = 1'b1;

    // R2: single write, R5 gain default read back
    rd_seq(8'h08, 1, "R5 gain default");
    wbuf[0] = 8'h1B; wr_seq(8'h08, 1, "R2");
    rd_seq(8'h08, 1, "R2 readback");

    // R3: burst write with increment
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
    wr_seq(8'h09, 3, "R3");
    // R4: burst read
    rd_seq(8'h08, 6, "R4");

    // R6: status reads and discarded status writes
    rd_seq(8'h00, 8, "R6 status");
    rd_seq(8'h13, 1, "R6 status 0x13");
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00; wr_seq(8'h03, 2, "R6 ro write");
    rd_seq(8'h03, 2, "R6 ro readback");

    // R7: holes read zero across the gap to 0x10, writes dropped
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h42; wbuf[3] = 8'h99;
    wr_seq(8'h0E, 4, "R7 hole write");
    rd_seq(8'h0D, 6, "R7 hole read");

    // R8: invalid frequency code
    wbuf[0] = 8'hF3; wr_seq(8'h0A, 1, "R8");
    rd_seq(8'h0A, 1, "R8 readback");
    wbuf[0] = 8'h06; wr_seq(8'h0A, 1, "R8 valid");
    rd_seq(8'h0A, 1, "R8 valid readback");

    // R9: self-clearing device reset bit
    wbuf[0] = 8'h85; wr_seq(8'h0C, 1, "R9");
    rd_seq(8'h08, 6, "R9 defaults");
    check("R9 ctrl", ctrl, ctrl_default_vec());

    // R10: stop inside a byte abandons it
    quiet = 1'b0;
    bus_start();
    send_byte(dev(strap, 1'b0), ack); check("R10 dev ack", ack, 1);
    send_byte(8'h0B, ack);            check("R10 sub ack", ack, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop(); wq(4); quiet = 1'b1;
    rd_seq(8'h0B, 1, "R10 untouched");

    // R1: strap change moves the address; R11 packing of last slot
    strap = 2'd3; wq(4);
    quiet = 1'b0;
    bus_start(); send_byte(dev(2'd0, 1'b0), ack); check("R1 old addr nack", ack, 0);
    bus_stop(); wq(4); quiet = 1'b1;
    wbuf[0] = 8'h77; wr_seq(8'h0D, 1, "R1 strap3");
    wbuf[0] = 8'h42; wr_seq(8'h10, 1, "R11");
    check("R11 slot6", ctrl[6*8 +: 8], 8'h42);
    rd_seq(8'hFF, 2, "R3 pointer wrap");

    done = 1'b1;
    report();
  end
endmodule